// File: doc/BRIEF.md
# Shared Attribute Store Arbiter

Two independent agents, a host and a local subsystem, share a single attribute store. The store is a 256-entry byte area that describes the card, plus eight byte-wide configuration registers. Each agent has its own clock and its own request, write-enable, index and write-data signals. It raises `req` and holds its other inputs steady until it sees a one-cycle `done` strobe in its own clock domain. After that it drops `req` and keeps it low for at least a dozen of its clock cycles before the next request.

Both requests pass through two-stage synchronizers into the arbitration domain. That domain runs on a fast input clock, and the actual arbitration steps happen on an enable pulse, `arb_tick`. This pulse comes once every 1, 2, 4 or 8 input cycles, as chosen by a static 2-bit select. On each tick the arbiter compares the two indices and the two operation types. It then decides which pending access goes ahead now, which one waits for a later tick, and which one is acknowledged but discarded. For correct operation the tick period must be no longer than one sixth of the shortest access cycle of either agent.

Both agents use the same word index. Index 0 to 255 selects the description area. Index 256 to 263 selects configuration registers 0 to 7. On a host bus this index is byte address bits 9:1, so every entry sits at an even byte address. The store has no reset.

Top module: `attr_mem_arbiter`

## Requirements
- R1: While `rst_n` is low and right after it is released, `host_done` and `sub_done` are 0 and `host_rdata` and `sub_rdata` are 0.
- R2: `arb_tick` is high for exactly one input clock cycle in every 2^`div_sel` cycles. `div_sel` = 0, 1, 2, 3 gives 64, 32, 16, 8 ticks over any 64 consecutive cycles.
- R3: Every request completes with exactly one single-cycle `done` pulse on the requester's side. A value written at an index by either agent is returned by a later read of that index by either agent.
- R4: When one agent reads an index and the other writes the same index on the same tick, the read is served first and returns the old value. The write is served on a later tick, so its `done` comes later and the new value is in place afterwards.
- R5: When both agents read the same index on the same tick, the host is served first and the subsystem on a later tick. Both get the same value.
- R6: When both agents write the same index on the same tick, the host value is stored. The subsystem still gets its `done`, on that same tick, but its data is discarded.
- R7: Accesses to different indices on the same tick are both served on that tick, so both `done` strobes appear together when the agent clocks are in phase.
- R8: Indices 256 to 263 are eight separate configuration registers that either agent can write and read back. They are distinct from index 255 of the description area.
- R9: Indices 264 to 511 hold nothing. A write there changes no stored entry, and a read there returns 0.
- R10: An acknowledge in the arbitration domain starts only on a cycle that follows an `arb_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbitration input clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| div_sel | input | 2 | Static tick divider select: divide by 2^div_sel |
| arb_tick | output | 1 | Arbitration step pulse, for monitoring |
| host_clk | input | 1 | Host agent clock |
| host_req | input | 1 | Host request level |
| host_we | input | 1 | Host write (1) or read (0) |
| host_idx | input | 9 | Host entry index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid from `host_done` onward |
| host_done | output | 1 | Host completion strobe, one host_clk cycle |
| sub_clk | input | 1 | Subsystem agent clock |
| sub_req | input | 1 | Subsystem request level |
| sub_we | input | 1 | Subsystem write (1) or read (0) |
| sub_idx | input | 9 | Subsystem entry index |
| sub_wdata | input | 8 | Subsystem write data |
| sub_rdata | output | 8 | Subsystem read data, valid from `sub_done` onward |
| sub_done | output | 1 | Subsystem completion strobe, one sub_clk cycle |

## Verification
The assertions watch every cycle of the arbitration domain. They check that an acknowledge begins only after a tick. They check that each same-index conflict gives the prescribed pattern of acknowledges on the next cycle: read alone, host alone, or both with the subsystem dropped. They check that different-index pairs are both acknowledged, and that ticks at divisions above one are never adjacent. Only the bench scenarios can show the data side of these rules. That covers old data returned to the reader, the host value surviving a write collision, and the ordering of the `done` strobes seen by the agents. It also covers the tick count per divider setting, the configuration registers, and the empty upper index range.

// File: rtl/attr_arb_pkg.sv
// Shared types for the attribute store arbiter.
package attr_arb_pkg;
    // Outcome of one arbitration step.
    typedef enum logic [1:0] {
        PICK_ALL       = 2'd0,  // every pending side proceeds
        PICK_HOST      = 2'd1,  // host only; subsystem waits
        PICK_SUB       = 2'd2,  // subsystem only; host waits
        PICK_HOST_DROP = 2'd3   // both acknowledged, subsystem write discarded
    } arb_pick_e;
endpackage

// File: rtl/attr_sync.sv
// Multi-stage level synchronizer into the domain of clk.
// Assumes: d is a slowly changing level; STAGES >= 2.
module attr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/attr_clk_div.sv
// Produces a one-cycle arbitration enable every 2^sel input cycles.
// Assumes: sel is static outside reset.
module attr_clk_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Free-running count of input cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Tick when all bits below the selected division are ones.
    always_comb begin
        mask = CNT_W'((1 << sel) - 1);
        tick = ((cnt_q & mask) == mask);
    end
endmodule

// File: rtl/attr_arb_decide.sv
// Combinational priority rules for one arbitration step.
// Assumes: pending flags already exclude acknowledged requests.
module attr_arb_decide
    import attr_arb_pkg::*;
(
    input  logic tick,
    input  logic h_pend,
    input  logic s_pend,
    input  logic h_we,
    input  logic s_we,
    input  logic match,
    output logic h_gnt,
    output logic s_gnt,
    output logic s_drop
);
    arb_pick_e pick;

    // Pick the outcome from the conflict type.
    always_comb begin
        pick = PICK_ALL;
        if (h_pend && s_pend && match) begin
            unique case ({h_we, s_we})
                2'b00:   pick = PICK_HOST;      // read tie: host first
                2'b01:   pick = PICK_HOST;      // host read before sub write
                2'b10:   pick = PICK_SUB;       // sub read before host write
                default: pick = PICK_HOST_DROP; // write collision
            endcase
        end
    end

    // Turn the outcome into grants, only on an arbitration step.
    always_comb begin
        h_gnt  = tick && h_pend && (pick != PICK_SUB);
        s_gnt  = tick && s_pend && (pick != PICK_HOST);
        s_drop = (pick == PICK_HOST_DROP);
    end
endmodule

// File: rtl/attr_store.sv
// Description area plus configuration registers, two write and two read ports.
// Port a has priority on a same-index write. No reset on contents.
// Assumes: CIS_DEPTH is a multiple of CFG_NUM.
module attr_store #(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 9,
    parameter int CIS_DEPTH = 256,
    parameter int CFG_NUM   = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [DATA_W-1:0] a_wd,
    output logic [DATA_W-1:0] a_rd,
    input  logic              b_we,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_rd
);
    localparam int             CIS_W   = $clog2(CIS_DEPTH);
    localparam int             CFG_W   = $clog2(CFG_NUM);
    localparam logic [IDX_W-1:0] CIS_LIM = IDX_W'(CIS_DEPTH);
    localparam logic [IDX_W-1:0] CFG_LIM = IDX_W'(CIS_DEPTH + CFG_NUM);

    logic [DATA_W-1:0] cis_mem [CIS_DEPTH];
    logic [DATA_W-1:0] cfg_q   [CFG_NUM];

    logic a_in_cis, a_in_cfg, b_in_cis, b_in_cfg, b_ok;

    // Region decode and port-b write qualification.
    always_comb begin
        a_in_cis = (a_idx < CIS_LIM);
        a_in_cfg = !a_in_cis && (a_idx < CFG_LIM);
        b_in_cis = (b_idx < CIS_LIM);
        b_in_cfg = !b_in_cis && (b_idx < CFG_LIM);
        b_ok     = b_we && !(a_we && (a_idx == b_idx));
    end

    // Description area writes.
    always_ff @(posedge clk) begin
        if (a_we && a_in_cis) cis_mem[a_idx[CIS_W-1:0]] <= a_wd;
        if (b_ok && b_in_cis) cis_mem[b_idx[CIS_W-1:0]] <= b_wd;
    end

    // One flop register per configuration entry.
    for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (a_we && a_in_cfg && (a_idx[CFG_W-1:0] == CFG_W'(g)))
                cfg_q[g] <= a_wd;
            else if (b_ok && b_in_cfg && (b_idx[CFG_W-1:0] == CFG_W'(g)))
                cfg_q[g] <= b_wd;
        end
    end

    // Read muxes; empty indices return zero.
    always_comb begin
        a_rd = '0;
        b_rd = '0;
        if (a_in_cis)      a_rd = cis_mem[a_idx[CIS_W-1:0]];
        else if (a_in_cfg) a_rd = cfg_q[a_idx[CFG_W-1:0]];
        if (b_in_cis)      b_rd = cis_mem[b_idx[CIS_W-1:0]];
        else if (b_in_cfg) b_rd = cfg_q[b_idx[CFG_W-1:0]];
    end
endmodule

// File: rtl/attr_mem_arbiter.sv
// Top level: synchronizes host and subsystem requests into the arbitration
// domain, applies the priority rules on each tick, accesses the store and
// returns a done strobe synchronized to each agent's clock.
// Assumes: each agent holds we/idx/wdata stable while req is high, and keeps
// req low after done until its done path has settled (about 12 agent cycles).
module attr_mem_arbiter #(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 9,
    parameter int CIS_DEPTH   = 256,
    parameter int CFG_NUM     = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    output logic              arb_tick,
    input  logic              host_clk,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    input  logic              sub_clk,
    input  logic              sub_req,
    input  logic              sub_we,
    input  logic [IDX_W-1:0]  sub_idx,
    input  logic [DATA_W-1:0] sub_wdata,
    output logic [DATA_W-1:0] sub_rdata,
    output logic              sub_done
);
    logic h_req_s, s_req_s, h_ack, s_ack, h_pend, s_pend, match;
    logic h_gnt, s_gnt, s_drop;
    logic [DATA_W-1:0] h_rd, s_rd;
    logic h_ack_a, s_ack_a, h_ack_d, s_ack_d;

    attr_clk_div #(.SEL_W(SEL_W)) i_div (
        .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(arb_tick)
    );

    attr_sync #(.STAGES(SYNC_STAGES)) i_hreq_sync (
        .clk(clk), .rst_n(rst_n), .d(host_req), .q(h_req_s)
    );
    attr_sync #(.STAGES(SYNC_STAGES)) i_sreq_sync (
        .clk(clk), .rst_n(rst_n), .d(sub_req), .q(s_req_s)
    );

    // Pending state and index comparison.
    always_comb begin
        h_pend = h_req_s && !h_ack;
        s_pend = s_req_s && !s_ack;
        match  = (host_idx == sub_idx);
    end

    attr_arb_decide i_decide (
        .tick(arb_tick), .h_pend(h_pend), .s_pend(s_pend),
        .h_we(host_we), .s_we(sub_we), .match(match),
        .h_gnt(h_gnt), .s_gnt(s_gnt), .s_drop(s_drop)
    );

    attr_store #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .CIS_DEPTH(CIS_DEPTH), .CFG_NUM(CFG_NUM)
    ) i_store (
        .clk(clk),
        .a_we(h_gnt && host_we), .a_idx(host_idx), .a_wd(host_wdata), .a_rd(h_rd),
        .b_we(s_gnt && sub_we && !s_drop), .b_idx(sub_idx), .b_wd(sub_wdata), .b_rd(s_rd)
    );

    // Host acknowledge and read capture in the arbitration domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_ack      <= 1'b0;
            host_rdata <= '0;
        end else if (h_gnt) begin
            h_ack <= 1'b1;
            if (!host_we) host_rdata <= h_rd;
        end else if (!h_req_s) begin
            h_ack <= 1'b0;
        end
    end

    // Subsystem acknowledge and read capture in the arbitration domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ack     <= 1'b0;
            sub_rdata <= '0;
        end else if (s_gnt) begin
            s_ack <= 1'b1;
            if (!sub_we) sub_rdata <= s_rd;
        end else if (!s_req_s) begin
            s_ack <= 1'b0;
        end
    end

    attr_sync #(.STAGES(SYNC_STAGES)) i_hack_sync (
        .clk(host_clk), .rst_n(rst_n), .d(h_ack), .q(h_ack_a)
    );
    attr_sync #(.STAGES(SYNC_STAGES)) i_sack_sync (
        .clk(sub_clk), .rst_n(rst_n), .d(s_ack), .q(s_ack_a)
    );

    // Host-side edge detector for the done strobe.
    always_ff @(posedge host_clk) begin
        if (!rst_n) h_ack_d <= 1'b0;
        else        h_ack_d <= h_ack_a;
    end

    // Subsystem-side edge detector for the done strobe.
    always_ff @(posedge sub_clk) begin
        if (!rst_n) s_ack_d <= 1'b0;
        else        s_ack_d <= s_ack_a;
    end

    assign host_done = h_ack_a && !h_ack_d;
    assign sub_done  = s_ack_a && !s_ack_d;
endmodule

// File: rtl/attr_arb_chk.sv
// Cycle checks on the arbitration domain, bound into attr_mem_arbiter.
module attr_arb_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] div_sel,
    input logic             arb_tick,
    input logic             h_pend,
    input logic             s_pend,
    input logic             h_we,
    input logic             s_we,
    input logic             match,
    input logic             h_ack,
    input logic             s_ack
);
    // R10
    ack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(h_ack) || $rose(s_ack)) |-> $past(arb_tick));

    // R4
    host_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && h_pend && s_pend && match && !h_we && s_we) |=> (h_ack && !s_ack));

    // R4
    sub_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && h_pend && s_pend && match && h_we && !s_we) |=> (s_ack && !h_ack));

    // R5
    read_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && h_pend && s_pend && match && !h_we && !s_we) |=> (h_ack && !s_ack));

    // R6
    write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && h_pend && s_pend && match && h_we && s_we) |=> (h_ack && s_ack));

    // R7
    no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && h_pend && s_pend && !match) |=> (h_ack && s_ack));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_tick && (div_sel != '0)) |=> !arb_tick);
endmodule

bind attr_mem_arbiter attr_arb_chk #(.SEL_W(SEL_W)) i_attr_arb_chk (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .arb_tick(arb_tick),
    .h_pend(h_pend), .s_pend(s_pend), .h_we(host_we), .s_we(sub_we),
    .match(match), .h_ack(h_ack), .s_ack(s_ack)
);

// File: tb/test_attr_mem_arbiter.sv
module test_attr_mem_arbiter;
    logic       clk = 0, host_clk = 0, sub_clk = 0;
    logic       rst_n = 0;
    logic [1:0] div_sel = 0;
    logic       arb_tick;
    logic       host_req = 0, host_we = 0, sub_req = 0, sub_we = 0;
    logic [8:0] host_idx = 0, sub_idx = 0;
    logic [7:0] host_wdata = 0, sub_wdata = 0, host_rdata, sub_rdata;
    logic       host_done, sub_done;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;        // 250 MHz
    always #5 host_clk = ~host_clk;
    always #5 sub_clk = ~sub_clk;

    attr_mem_arbiter i_attr_mem_arbiter (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .arb_tick(arb_tick),
        .host_clk(host_clk), .host_req(host_req), .host_we(host_we),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done),
        .sub_clk(sub_clk), .sub_req(sub_req), .sub_we(sub_we),
        .sub_idx(sub_idx), .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
        .sub_done(sub_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 0;
        host_req = 0;
        sub_req = 0;
        div_sel = sel;
        repeat (12) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_host(output time t);
        int n = 0;
        do begin
            @(negedge host_clk);
            n++;
        end while (!host_done && n < 2000);
        t = $time;
        chk(n < 2000, "R3 host done timeout", n, 0);
    endtask

    task automatic wait_sub(output time t);
        int n = 0;
        do begin
            @(negedge sub_clk);
            n++;
        end while (!sub_done && n < 2000);
        t = $time;
        chk(n < 2000, "R3 sub done timeout", n, 0);
    endtask

    task automatic settle();
        host_req = 0;
        sub_req = 0;
        repeat (14) @(negedge host_clk);
    endtask

    task automatic host_op(input logic we, input logic [8:0] idx, input logic [7:0] wd,
                           output logic [7:0] rd);
        time t;
        @(negedge clk);
        host_we = we; host_idx = idx; host_wdata = wd; host_req = 1;
        wait_host(t);
        rd = host_rdata;
        @(negedge host_clk);
        chk(host_done == 0, "R3 host done single pulse", host_done, 0);
        settle();
    endtask

    task automatic sub_op(input logic we, input logic [8:0] idx, input logic [7:0] wd,
                          output logic [7:0] rd);
        time t;
        @(negedge clk);
        sub_we = we; sub_idx = idx; sub_wdata = wd; sub_req = 1;
        wait_sub(t);
        rd = sub_rdata;
        @(negedge sub_clk);
        chk(sub_done == 0, "R3 sub done single pulse", sub_done, 0);
        settle();
    endtask

    task automatic pair(input logic hwe, input logic [8:0] hi, input logic [7:0] hd,
                        input logic swe, input logic [8:0] si, input logic [7:0] sd,
                        output time th, output time ts,
                        output logic [7:0] hrd, output logic [7:0] srd);
        @(negedge clk);
        host_we = hwe; host_idx = hi; host_wdata = hd;
        sub_we = swe; sub_idx = si; sub_wdata = sd;
        host_req = 1; sub_req = 1;
        fork
            wait_host(th);
            wait_sub(ts);
        join
        hrd = host_rdata;
        srd = sub_rdata;
        settle();
    endtask

    task automatic t_reset();
        do_reset(2'd0);
        chk(host_done == 0 && sub_done == 0, "R1 done low after reset",
            {host_done, sub_done}, 0);
        chk(host_rdata == 0, "R1 host_rdata zero", host_rdata, 0);
        chk(sub_rdata == 0, "R1 sub_rdata zero", sub_rdata, 0);
    endtask

    task automatic t_divider();
        for (int s = 0; s < 4; s++) begin
            int cnt = 0;
            do_reset(2'(s));
            for (int c = 0; c < 64; c++) begin
                @(negedge clk);
                if (arb_tick) cnt++;
            end
            chk(cnt == (64 >> s), $sformatf("R2 tick count sel=%0d", s), cnt, 64 >> s);
        end
    endtask

    task automatic t_basic();
        logic [7:0] rd;
        host_op(1, 9'd5, 8'h11, rd);
        sub_op(0, 9'd5, 8'h00, rd);
        chk(rd == 8'h11, "R3 sub reads host write", rd, 8'h11);
        sub_op(1, 9'd200, 8'h22, rd);
        host_op(0, 9'd200, 8'h00, rd);
        chk(rd == 8'h22, "R3 host reads sub write", rd, 8'h22);
    endtask

    task automatic t_cfg();
        logic [7:0] rd;
        host_op(1, 9'd255, 8'h3C, rd);
        host_op(1, 9'd259, 8'hA5, rd);
        sub_op(1, 9'd263, 8'h7E, rd);
        sub_op(1, 9'd256, 8'h01, rd);
        sub_op(0, 9'd259, 8'h00, rd);
        chk(rd == 8'hA5, "R8 cfg reg 3 readback", rd, 8'hA5);
        host_op(0, 9'd263, 8'h00, rd);
        chk(rd == 8'h7E, "R8 cfg reg 7 readback", rd, 8'h7E);
        host_op(0, 9'd256, 8'h00, rd);
        chk(rd == 8'h01, "R8 cfg reg 0 readback", rd, 8'h01);
        host_op(0, 9'd255, 8'h00, rd);
        chk(rd == 8'h3C, "R8 last area entry distinct", rd, 8'h3C);
    endtask

    task automatic t_range();
        logic [7:0] rd;
        host_op(1, 9'd264, 8'h5A, rd);
        sub_op(1, 9'd511, 8'h6B, rd);
        host_op(0, 9'd264, 8'h00, rd);
        chk(rd == 8'h00, "R9 empty index reads zero", rd, 0);
        sub_op(0, 9'd511, 8'h00, rd);
        chk(rd == 8'h00, "R9 empty index 511 reads zero", rd, 0);
        host_op(0, 9'd256, 8'h00, rd);
        chk(rd == 8'h01, "R9 cfg reg 0 untouched", rd, 8'h01);
        host_op(0, 9'd8, 8'h00, rd);
        chk(rd == 8'h44, "R9 area entry 8 untouched", rd, 8'h44);
    endtask

    task automatic t_rd_wr();
        time th, ts;
        logic [7:0] hr, sr, rd;
        host_op(1, 9'd40, 8'h10, rd);
        pair(0, 9'd40, 8'h00, 1, 9'd40, 8'h20, th, ts, hr, sr);
        chk(hr == 8'h10, "R4 host read sees old data", hr, 8'h10);
        chk(th < ts, "R4 sub write done after host read", int'(ts - th), 1);
        host_op(0, 9'd40, 8'h00, rd);
        chk(rd == 8'h20, "R4 sub write applied afterwards", rd, 8'h20);
    endtask

    task automatic t_wr_rd();
        time th, ts;
        logic [7:0] hr, sr, rd;
        sub_op(1, 9'd41, 8'h31, rd);
        pair(1, 9'd41, 8'h32, 0, 9'd41, 8'h00, th, ts, hr, sr);
        chk(sr == 8'h31, "R4 sub read sees old data", sr, 8'h31);
        chk(ts < th, "R4 host write done after sub read", int'(th - ts), 1);
        sub_op(0, 9'd41, 8'h00, rd);
        chk(rd == 8'h32, "R4 host write applied afterwards", rd, 8'h32);
    endtask

    task automatic t_rd_rd();
        time th, ts;
        logic [7:0] hr, sr, rd;
        host_op(1, 9'd258, 8'h9C, rd);
        pair(0, 9'd258, 8'h00, 0, 9'd258, 8'h00, th, ts, hr, sr);
        chk(th < ts, "R5 host served first", int'(ts - th), 1);
        chk(hr == 8'h9C && sr == 8'h9C, "R5 both read same value", {hr, sr}, 16'h9C9C);
    endtask

    task automatic t_wr_wr();
        time th, ts;
        logic [7:0] hr, sr, rd;
        pair(1, 9'd77, 8'hAA, 1, 9'd77, 8'hBB, th, ts, hr, sr);
        chk(th == ts, "R6 both acknowledged on one tick", int'(ts - th), 0);
        sub_op(0, 9'd77, 8'h00, rd);
        chk(rd == 8'hAA, "R6 host write kept", rd, 8'hAA);
        pair(1, 9'd260, 8'h0F, 1, 9'd260, 8'hF0, th, ts, hr, sr);
        host_op(0, 9'd260, 8'h00, rd);
        chk(rd == 8'h0F, "R6 host write kept in cfg reg", rd, 8'h0F);
    endtask

    task automatic t_diff();
        time th, ts;
        logic [7:0] hr, sr, rd;
        pair(1, 9'd8, 8'h44, 1, 9'd9, 8'h55, th, ts, hr, sr);
        chk(th == ts, "R7 different writes same tick", int'(ts - th), 0);
        host_op(0, 9'd9, 8'h00, rd);
        chk(rd == 8'h55, "R7 sub write stored", rd, 8'h55);
        sub_op(0, 9'd8, 8'h00, rd);
        chk(rd == 8'h44, "R7 host write stored", rd, 8'h44);
        pair(0, 9'd9, 8'h00, 1, 9'd10, 8'h66, th, ts, hr, sr);
        chk(th == ts && hr == 8'h55, "R7 read and write different indices", hr, 8'h55);
    endtask

    initial begin
        #400us;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_divider();
        do_reset(2'd0);
        t_basic();
        t_cfg();
        do_reset(2'd3);
        t_rd_wr();
        t_wr_rd();
        t_rd_rd();
        t_wr_wr();
        t_diff();
        t_range();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule